// File: doc/BRIEF.md
# Dual-Modulus 15/16 Prescaler

This block divides a fast input clock by 15 or by 16. It is the front end of the feedback divider in a frequency synthesizer. A control input picks the modulus, and a loop controller can change it from one output period to the next, so the average ratio can sit between the two integers.

Internally there are two stages. The first is a synchronous stage that divides by 4 by default and divides by 3 on request. The second is a two-bit ripple counter clocked by the first stage's output, which divides by 4. For the 15 modulus, the first stage takes its short (divide-by-3) pass exactly once per output period: only while the ripple counter holds its all-ones state. The modulus request is captured once per period, at the output rising edge, so a change never splits a period.

The counting cell is parameterised on its long ratio. With its default setting it is a 2/3 cell that divides by 3, or by 2 when its shorten input is high. The same leaf, set to a long ratio of 4, forms the first stage.

Top module: `dual_mod_prescaler`

## Requirements
- R1: While `rst` is high at a rising `clk_in` edge, `div_clk` is low after that edge and stays low until reset is released.
- R2: After reset is released, the first rising edge of `div_clk` occurs at the 6th rising `clk_in` edge at which `rst` is low.
- R3: When `mod_sel` is 0 at the `clk_in` edge where `div_clk` rises, the next rising edge of `div_clk` follows exactly 16 `clk_in` edges later.
- R4: When `mod_sel` is 1 at the `clk_in` edge where `div_clk` rises, the next rising edge of `div_clk` follows exactly 15 `clk_in` edges later. The first stage takes one 3-cycle pass and three 4-cycle passes.
- R5: Only the value of `mod_sel` at the edge where `div_clk` rises decides the length of the period that begins there. Changes of `mod_sel` at any other edge have no effect on that period. `div_clk` rises only together with a rising edge of the first-stage output.
- R6: A reset applied in the middle of operation restarts the sequence, so the first rise after it again comes at the 6th edge. This holds whatever modulus was active before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Active-high reset. It acts synchronously on the first stage and immediately on the ripple stage |
| mod_sel | input | 1 | Modulus request: 1 selects divide-by-15, 0 selects divide-by-16 |
| div_clk | output | 1 | Divided clock; its rising edges mark period boundaries |

## Verification
A rising edge of `div_clk` appears right after the `clk_in` edge that causes it. The bench therefore samples at the following falling edge and credits the rise to the edge just counted. The modulus that governs a period is the `mod_sel` value present at the rise edge. The bench drives inputs 1 ns after a falling edge, so the model reads exactly that value when it schedules the next expected rise 15 or 16 edges ahead. Every clock, the model compares the expected rise event with the observed one. Any early, late or missing rise is flagged, including across reset and while `mod_sel` toggles every cycle.

// File: rtl/presc_pkg.sv
package presc_pkg;

  // Length in input cycles of one pass of a counting cell.
  function automatic int cell_len(input int long_div, input logic shorten);
    return shorten ? long_div - 1 : long_div;
  endfunction

  // Output period for a cell followed by a ripple counter of 'stages' bits,
  // with at most one shortened pass per period.
  function automatic int total_div(input int long_div, input int stages,
                                   input logic shorten);
    return (long_div << stages) - (shorten ? 1 : 0);
  endfunction

  // Input edge (counted from reset release) of the first output rise.
  function automatic int first_rise(input int long_div, input int stages);
    return (long_div / 2) + long_div * ((1 << (stages - 1)) - 1);
  endfunction

endpackage

// File: rtl/dm_count_cell.sv
// Synchronous dual-ratio counting cell: divides by LONG_DIV, or by
// LONG_DIV-1 when 'shorten' is high as the count reaches its next-to-last state.
module dm_count_cell #(
  parameter int LONG_DIV = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic shorten,
  output logic cell_out,
  output logic rise_next
);
  localparam int CW = $clog2(LONG_DIV);
  localparam logic [CW-1:0] LAST_LONG  = CW'(LONG_DIV - 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(LONG_DIV - 2);
  localparam logic [CW-1:0] HALF_V     = CW'(LONG_DIV / 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          wrap;
  logic          out_q;

  always_comb begin
    wrap  = (cnt_q == LAST_LONG) || (shorten && (cnt_q == LAST_SHORT));
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= (cnt_d >= HALF_V);
    end
  end

  assign cell_out  = out_q;
  // High in the cycle before the output rises.
  assign rise_next = ~out_q & (cnt_d >= HALF_V);
endmodule

// File: rtl/ripple_div.sv
// Ripple counter: each bit is clocked by the falling edge of the bit below,
// and bit 0 by the rising edge of 'tick'. Reset clears it at once.
module ripple_div #(
  parameter int STAGES = 2
) (
  input  logic              rst,
  input  logic              tick,
  output logic [STAGES-1:0] q
);
  logic [STAGES:0] rclk;
  assign rclk[0] = tick;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_bit
    logic bit_q;
    always_ff @(posedge rclk[gi] or posedge rst) begin
      if (rst) bit_q <= 1'b0;
      else     bit_q <= ~bit_q;
    end
    assign q[gi]        = bit_q;
    assign rclk[gi + 1] = ~bit_q;
  end
endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler #(
  parameter int FIRST_LONG    = 4,
  parameter int RIPPLE_STAGES = 2
) (
  input  logic clk_in,
  input  logic rst,
  input  logic mod_sel,
  output logic div_clk
);
  localparam logic [RIPPLE_STAGES-1:0] SWALLOW_STATE = '1;
  localparam logic [RIPPLE_STAGES-1:0] PRE_BOUND     = SWALLOW_STATE >> 1;

  logic                     s1_out;
  logic                     s1_rise_next;
  logic                     swallow;
  logic                     boundary_next;
  logic                     mode15_q;
  logic [RIPPLE_STAGES-1:0] rip_q;

  // The output rises at the next edge: the ripple count is about to set its MSB.
  assign boundary_next = s1_rise_next && (rip_q == PRE_BOUND);
  // One short pass per period, in the single all-ones ripple state.
  assign swallow       = mode15_q && (rip_q == SWALLOW_STATE);

  always_ff @(posedge clk_in) begin
    if (rst)                mode15_q <= 1'b0;
    else if (boundary_next) mode15_q <= mod_sel;
  end

  dm_count_cell #(.LONG_DIV(FIRST_LONG)) u_first (
    .clk      (clk_in),
    .rst      (rst),
    .shorten  (swallow),
    .cell_out (s1_out),
    .rise_next(s1_rise_next)
  );

  ripple_div #(.STAGES(RIPPLE_STAGES)) u_ripple (
    .rst (rst),
    .tick(s1_out),
    .q   (rip_q)
  );

  assign div_clk = rip_q[RIPPLE_STAGES-1];
endmodule

// File: rtl/dual_mod_prescaler_chk.sv
module dual_mod_prescaler_chk #(
  parameter int FIRST_LONG    = 4,
  parameter int RIPPLE_STAGES = 2
) (
  input logic clk_in,
  input logic rst,
  input logic mod_sel,
  input logic div_clk,
  input logic s1_out,
  input logic boundary_next,
  input logic mode15_q
);
  localparam int P16   = presc_pkg::total_div(FIRST_LONG, RIPPLE_STAGES, 1'b0);
  localparam int P15   = presc_pkg::total_div(FIRST_LONG, RIPPLE_STAGES, 1'b1);
  localparam int FIRST = presc_pkg::first_rise(FIRST_LONG, RIPPLE_STAGES);

  logic div_d, ms_d, seen, mode_at_rise, rise;
  int   gap, since;

  assign rise = div_clk & ~div_d;

  always_ff @(posedge clk_in) begin
    if (rst) begin
      div_d <= 1'b0; ms_d <= 1'b0; seen <= 1'b0; mode_at_rise <= 1'b0;
      gap <= 0; since <= 0;
    end else begin
      div_d <= div_clk;
      ms_d  <= mod_sel;
      since <= since + 1;
      gap   <= rise ? 1 : gap + 1;
      if (rise) begin
        seen         <= 1'b1;
        mode_at_rise <= ms_d;
      end
    end
  end

  // R1
  reset_low_chk: assert property (@(posedge clk_in) rst |=> !div_clk);
  // R2 (and R6 after a mid-run reset)
  first_rise_chk: assert property (@(posedge clk_in) disable iff (rst)
    (rise && !seen) |-> (since == FIRST));
  // R3
  period16_chk: assert property (@(posedge clk_in) disable iff (rst)
    (rise && seen && !mode_at_rise) |-> (gap == P16));
  // R4
  period15_chk: assert property (@(posedge clk_in) disable iff (rst)
    (rise && seen && mode_at_rise) |-> (gap == P15));
  // R5
  mode_hold_chk: assert property (@(posedge clk_in) disable iff (rst)
    !boundary_next |=> $stable(mode15_q));
  // R5
  boundary_align_chk: assert property (@(posedge clk_in) disable iff (rst)
    $rose(div_clk) |-> $rose(s1_out));
endmodule

bind dual_mod_prescaler dual_mod_prescaler_chk #(
  .FIRST_LONG(FIRST_LONG), .RIPPLE_STAGES(RIPPLE_STAGES)
) u_chk (
  .clk_in       (clk_in),
  .rst          (rst),
  .mod_sel      (mod_sel),
  .div_clk      (div_clk),
  .s1_out       (s1_out),
  .boundary_next(boundary_next),
  .mode15_q     (mode15_q)
);

// File: tb/dual_mod_prescaler_bench.sv
`timescale 1ns/1ps
module dual_mod_prescaler_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mod_sel = 1'b0;
  logic div_clk;

  int    checks = 0;
  int    failures = 0;
  int    phase = 0;
  int    edge_n = 0;
  int    next_rise = 6;
  bit    prev_div = 1'b0;
  bit    done = 1'b0;
  string tag = "R2";

  always #2 clk = ~clk;

  dual_mod_prescaler u_dual_mod_prescaler (
    .clk_in (clk),
    .rst    (rst),
    .mod_sel(mod_sel),
    .div_clk(div_clk)
  );

  // Reference model: counts edges, expects a rise 6 edges after reset release,
  // then 15 or 16 edges after each rise depending on mod_sel at that rise.
  always @(negedge clk) begin
    bit act_rise, exp_rise;
    act_rise = (div_clk === 1'b1) && !prev_div;
    prev_div = (div_clk === 1'b1);
    if (rst) begin
      edge_n    = 0;
      next_rise = 6;
      tag       = (phase >= 3) ? "R6" : "R2";
      checks++;
      if (div_clk !== 1'b0) begin
        failures++;
        $display("FAIL R1 div_clk during reset actual=%b expected=0", div_clk);
      end
    end else begin
      edge_n++;
      exp_rise = (edge_n == next_rise);
      if (exp_rise || act_rise) begin
        checks++;
        if (exp_rise != act_rise) begin
          failures++;
          $display("FAIL %s edge=%0d actual_rise=%0b expected_rise=%0b",
                   tag, edge_n, act_rise, exp_rise);
        end
      end
      if (exp_rise) begin
        next_rise = edge_n + (mod_sel ? 15 : 16);
        tag = (phase == 2) ? "R5" : (mod_sel ? "R4" : "R3");
      end
    end
  end

  task automatic drive(input logic r, input logic m);
    @(negedge clk);
    #1;
    rst = r;
    mod_sel = m;
  endtask

  // kind: 0 holds mod_sel low, 1 holds it high, 2 toggles it every cycle
  task automatic run(input int n, input int kind);
    for (int i = 0; i < n; i++) begin
      if (kind == 2) drive(1'b0, ~mod_sel);
      else           drive(1'b0, kind[0]);
    end
  endtask

  initial begin
    // R1 reset state, then R2 first rise and R3 period of 16
    phase = 0;
    repeat (5) drive(1'b1, 1'b0);
    phase = 1;
    run(70, 0);
    // R4 period of 15
    run(80, 1);
    // R5 mod_sel toggling: only the value at each rise matters
    phase = 2;
    run(200, 2);
    run(40, 0);
    // R6 mid-run reset with the 15 modulus active
    phase = 3;
    repeat (3) drive(1'b1, 1'b1);
    run(60, 1);
    run(40, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule